// File: doc/BRIEF.md
# Opcode Fetch Sequencer with Prefix Skipping

This block is the instruction-fetch front end of a small 8-bit processor. It owns the program counter, raises a fetch strobe (`sync`) in every opcode-fetch cycle, and decodes the opcode byte presented on `data_in` in that same cycle. Some opcodes, picked by their low nibble, are single-cycle no-operations. Such an opcode never reaches the execute stage, and the very next cycle is another opcode fetch.

Every other opcode goes to a built-in execution stub. The sequencer raises a start pulse in the fetch cycle. The stub then counts out a fixed number of execute cycles, taken from a small computed table, and flags completion in the last of them. Interrupt requests are considered only at the boundary after an ordinary instruction completes. A chain of single-cycle no-operations therefore forms one atomic unit together with the ordinary instruction that follows it. Accepting an interrupt produces a one-cycle `irq_taken` pulse in place of the next fetch. Stack pushes and vector fetch belong to other logic.

Top module: `opfetch_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pc` equals the parameter `RESET_PC`, `sync` is high and `irq_taken` is low.
- R2: An opcode whose low nibble is 0x3 or 0xB is a single-cycle no-operation. In its fetch cycle `exec_start` stays low, and the following cycle is again a fetch with `sync` high.
- R3: With `cfg_wide` high, opcodes with low nibble 0x7 or 0xF are also single-cycle no-operations. With `cfg_wide` low they are ordinary instructions.
- R4: `pc` increments by one after every fetch cycle, including no-operation fetches. It holds its value in execute and interrupt cycles.
- R5: An ordinary opcode raises `exec_start` in its fetch cycle. `sync` is then low for 1 + opcode[1:0] execute cycles, and `exec_done` is high only in the last of them.
- R6: Opcode 0xEA is an ordinary instruction with exactly one execute cycle, so it takes two cycles in total.
- R7: If `irq` and `irq_en` are both high in the `exec_done` cycle, the next cycle has `irq_taken` high, `sync` low and `pc` unchanged, and the cycle after that is a fetch.
- R8: No interrupt is taken at the boundary right after a single-cycle no-operation, even while `irq` and `irq_en` are high.
- R9: With `irq_en` low, a high `irq` has no effect, and a fetch follows every `exec_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wide | input | 1 | Widens the no-operation set to four low nibbles |
| irq | input | 1 | Level-sensitive interrupt request |
| irq_en | input | 1 | Interrupt enable mask |
| data_in | input | 8 | Opcode byte, valid in fetch cycles |
| pc | output | PC_W | Program counter |
| sync | output | 1 | High in opcode-fetch cycles |
| irq_taken | output | 1 | One-cycle interrupt acceptance pulse |
| exec_start | output | 1 | Ordinary opcode handed to the execute stub |
| exec_done | output | 1 | Last execute cycle of the current instruction |

## Verification
The same opcode mix is run with `cfg_wide` low and then high. Only the 0x7 and 0xF columns change behaviour between the two runs, which separates the narrow no-operation set from the wide one. Programs that mix no-operation chains, 0xEA and opcodes with every value of bits [1:0] check the execute-cycle table and the `pc` stepping. Holding `irq` high with the mask set and then with it clear shows that interrupts are accepted after every ordinary instruction, never after a no-operation, and never when the mask is clear.

// File: rtl/opfetch_seq.sv
module opfetch_seq #(
  parameter int PC_W = 16,
  parameter logic [PC_W-1:0] RESET_PC = 'h0200,
  parameter int CNT_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wide,
  input  logic            irq,
  input  logic            irq_en,
  input  logic [7:0]      data_in,
  output logic [PC_W-1:0] pc,
  output logic            sync,
  output logic            irq_taken,
  output logic            exec_start,
  output logic            exec_done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_IRQ} st_t;
  st_t st;
  logic [CNT_W-1:0] left;
  logic is_nop;
  logic [CNT_W-1:0] exec_len;

  assign is_nop   = (data_in[1:0] == 2'b11) && (cfg_wide || !data_in[2]);
  assign exec_len = (data_in == 8'hEA) ? ONE : CNT_W'(data_in[1:0]) + ONE;

  assign sync       = (st == S_FETCH);
  assign irq_taken  = (st == S_IRQ);
  assign exec_start = sync && !is_nop;
  assign exec_done  = (st == S_EXEC) && (left == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_FETCH;
      pc   <= RESET_PC;
      left <= '0;
    end else begin
      case (st)
        S_FETCH: begin
          pc <= pc + 1'b1;
          if (!is_nop) begin
            st   <= S_EXEC;
            left <= exec_len;
          end
        end
        S_EXEC: begin
          left <= left - ONE;
          if (left == ONE) st <= (irq && irq_en) ? S_IRQ : S_FETCH;
        end
        default: st <= S_FETCH;
      endcase
    end
  end

  // R2
  nop_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && is_nop) |=> sync);
  // R8
  nop_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && is_nop) |=> !irq_taken);
  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (pc == $past(pc) + 1'b1));
  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(pc));
  // R5
  start_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !sync);
  // R7
  irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> $past(exec_done));
  // R7
  irq_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |=> sync);
  // R9
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_done && !irq_en) |=> sync);
endmodule

// File: tb/opfetch_seq_test.sv
`timescale 1ns/1ps
module opfetch_seq_test;
  localparam logic [15:0] RPC = 16'h0200;

  logic clk = 1'b0, rst_n = 1'b0, cfg_wide = 1'b0, irq = 1'b0, irq_en = 1'b0;
  logic [7:0] data_in;
  logic [15:0] pc;
  logic sync, irq_taken, exec_start, exec_done;
  logic [7:0] prog [0:255];
  int checks = 0, fails = 0;
  bit hung = 0;

  typedef struct packed {
    logic s, t, st, d;
    logic [15:0] a;
  } item_t;
  item_t q[$];
  string tq[$];

  always #4 clk = ~clk;
  assign data_in = prog[pc[7:0]];

  opfetch_seq #(.PC_W(16), .RESET_PC(RPC), .CNT_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .irq(irq), .irq_en(irq_en),
    .data_in(data_in), .pc(pc), .sync(sync), .irq_taken(irq_taken),
    .exec_start(exec_start), .exec_done(exec_done));

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  function automatic bit nop_of(input logic [7:0] op, input bit wide);
    return (op[1:0] == 2'b11) && (wide || !op[2]);
  endfunction

  // Monitor: pops one expected item per cycle and compares
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t e, g;
      string tg;
      e = q.pop_front();
      tg = tq.pop_front();
      g = '{s: sync, t: irq_taken, st: exec_start, d: exec_done, a: pc};
      check(g == e, tg, $sformatf("got s%0b t%0b st%0b d%0b pc=%h expected s%0b t%0b st%0b d%0b pc=%h",
        g.s, g.t, g.st, g.d, g.a, e.s, e.t, e.st, e.d, e.a));
    end
  end

  // Driver: builds the expected cycle trace from the requirements
  task automatic run(input bit wide, input bit rq, input bit en, input int nops);
    logic [15:0] a = RPC;
    rst_n = 1'b0;
    cfg_wide = wide; irq = rq; irq_en = en;
    for (int k = 0; k < nops; k++) begin
      logic [7:0] op = prog[a[7:0]];
      int n;
      if (nop_of(op, wide)) begin
        q.push_back('{1'b1, 1'b0, 1'b0, 1'b0, a});
        tq.push_back(((op[3:0] == 4'h7) || (op[3:0] == 4'hF)) ? "R3" : "R2");
        a++;
        continue;
      end
      q.push_back('{1'b1, 1'b0, 1'b1, 1'b0, a});
      tq.push_back("R5");
      a++;
      n = (op == 8'hEA) ? 1 : 1 + int'(op[1:0]);
      for (int c = 1; c <= n; c++) begin
        q.push_back('{1'b0, 1'b0, 1'b0, (c == n), a});
        tq.push_back(op == 8'hEA ? "R6" : "R5");
      end
      if (rq && en) begin
        q.push_back('{1'b0, 1'b1, 1'b0, 1'b0, a});
        tq.push_back("R7");
      end
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    while (q.size() > 0 && !hung) @(posedge clk);
    #1 rst_n = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) prog[i] = 8'hEA;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(sync === 1'b1 && pc === RPC && irq_taken === 1'b0, "R1",
      $sformatf("got sync=%b pc=%h taken=%b expected 1 %h 0", sync, pc, irq_taken, RPC));

    begin
      logic [7:0] p1 [8] = '{8'h03, 8'h0B, 8'hEA, 8'h01, 8'h12, 8'h07, 8'h0F, 8'hA9};
      for (int i = 0; i < 8; i++) prog[i] = p1[i];
    end
    run(1'b0, 1'b0, 1'b0, 8);   // narrow set: R2 R4 R5 R6
    run(1'b1, 1'b0, 1'b0, 8);   // wide set: R3
    begin
      logic [7:0] p2 [8] = '{8'h03, 8'h13, 8'hAB, 8'hEA, 8'h02, 8'h3B, 8'h01, 8'hF3};
      for (int i = 0; i < 8; i++) prog[i] = p2[i];
    end
    run(1'b0, 1'b1, 1'b1, 8);   // R7 R8: taken only after ordinary ops
    run(1'b0, 1'b1, 1'b0, 8);   // R9: masked
    run(1'b1, 1'b1, 1'b1, 8);   // R8 with wide set

    if (hung) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    hung = 1;
    q.delete();
    tq.delete();
  end
endmodule